// File: doc/BRIEF.md
# ADC Offset Self-Calibration Sequencer

This block finds the offset-trim code of a successive-approximation converter without software running the loop. Once started, it looks for the trim code by bisection. For each trial it presents a candidate code on a register-write port and then requests one conversion through a request/done handshake. The converted value moves one of the two search bounds: a zero reading means the offset is already cancelled, and any other reading means it is not.

Each bisection ends with one extra trial at the code one above the last midpoint, and that code is the result of the search. The search runs ten times. The smallest and the largest of the ten results are discarded. The other eight are averaged, and the average is rounded half up. The rounded average is returned with a one-cycle done pulse.

The caller chooses which of two converters to calibrate. It also chooses whether the converter samples a real input channel or an internal ground. For the ground option, the block drives a channel number that is deliberately not a valid input. A per-converter record of the last code written suppresses write strobes that would not change the trim register.

Top module: `cal_engine`

## Requirements
- R1: Every search starts with an upper bound of 4096 and a lower bound of 0. Its first trial code is 2048, the integer mean of the bounds.
- R2: After a trial, a conversion result of zero sets the upper bound to the trial code, and any non-zero result sets the lower bound to it. The next trial code is the integer mean of the new bounds.
- R3: When the bounds are exactly one apart, the trial code is raised by one and converted once more, and that raised code is the search result. With these bounds, every search makes exactly 14 conversions.
- R4: One calibration runs the search 10 times, which is 140 conversions in all.
- R5: Exactly one smallest and one largest search result are removed, and the remaining eight are summed.
- R6: The final code is the sum divided by 8. It is rounded down when the remainder is 0 to 3 and rounded up when the remainder is 4 to 7.
- R7: During a calibration, `conv_unit_o` equals the converter chosen at start (0 or 1). `conv_chan_o` equals `chan_i` captured at start, unless internal ground was chosen. With internal ground it is 4'hF for converter 0 and 4'h1 for converter 1.
- R8: `trial_we_o` pulses only when the trial code differs from the last code written to the same converter. Each converter keeps its own record, and both records reset to all ones (13'h1FFF).
- R9: Each write strobe lasts one cycle and ends before the conversion request rises. The request stays high until `conv_done_i` is seen, and it is never high while the block is idle.
- R10: `start_i` is ignored while `busy_o` is high. The running calibration keeps its converter, its channel and its results.
- R11: `done_o` is high for exactly one cycle, while `busy_o` is still high. `final_code_o` changes only in that cycle and holds its value afterwards.
- R12: After reset, `busy_o`, `done_o`, `conv_req_o` and `trial_we_o` are low and `final_code_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calibration (taken only when idle) |
| conv_sel_i | input | 1 | Converter to calibrate |
| int_gnd_i | input | 1 | Calibrate against internal ground |
| chan_i | input | 4 | Input channel for calibration on a real input |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| final_code_o | output | 13 | Averaged trim code |
| trial_code_o | output | 13 | Candidate trim code |
| trial_we_o | output | 1 | Write strobe for the candidate code |
| conv_req_o | output | 1 | Conversion request |
| conv_unit_o | output | 1 | Converter addressed by write and request |
| conv_chan_o | output | 4 | Channel the converter samples |
| conv_done_i | input | 1 | Conversion finished |
| conv_result_i | input | 12 | Conversion result |

## Verification
When start is accepted, the first write strobe appears two cycles later, and the request rises in the cycle after the strobe. Each later strobe comes two cycles after the edge that samples `conv_done_i`. The done pulse comes two edges after the edge that samples the last conversion of the tenth search. The converter model in the bench holds `conv_done_i` back by 0, 1 or 2 cycles, so these delays shift from trial to trial. For that reason the scoreboard compares strobed codes and final codes in the order they occur, sampling on the falling edge, and the exact cycle spacing is left to the bound properties.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_WRITE,
    ST_REQ,
    ST_UPDATE,
    ST_AVG,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/cal_code_writer.sv
// Holds the last code written to each converter and raises the write
// strobe only when a new trial code would change that converter's register.
module cal_code_writer #(
  parameter int CODE_W   = 13,
  parameter int NUM_CONV = 2,
  parameter int UNIT_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] trial_code_o,
  output logic              trial_we_o
);
  logic [NUM_CONV-1:0][CODE_W-1:0] last_q;
  logic [NUM_CONV-1:0]             hit;
  logic [CODE_W-1:0]               code_q;
  logic                            we_q;

  genvar g;
  generate
    for (g = 0; g < NUM_CONV; g++) begin : g_hit
      assign hit[g] = (unit_i == UNIT_W'(g)) && (last_q[g] != code_i);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '1;
      code_q <= '0;
      we_q   <= 1'b0;
    end else begin
      we_q <= wr_req_i && (|hit);
      if (wr_req_i) begin
        code_q <= code_i;
        for (int i = 0; i < NUM_CONV; i++) begin
          if (hit[i]) last_q[i] <= code_i;
        end
      end
    end
  end

  assign trial_code_o = code_q;
  assign trial_we_o   = we_q;
endmodule

// File: rtl/cal_trim_avg.sv
// Collects the per-search results and forms the trimmed, rounded mean.
module cal_trim_avg #(
  parameter int CODE_W = 13,
  parameter int REPS   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [CODE_W-1:0] val_i,
  input  logic              fin_i,
  output logic [CODE_W-1:0] final_o,
  output logic              done_o
);
  localparam int SUM_W   = CODE_W + $clog2(REPS);
  localparam int KEEP    = REPS - 2;
  localparam int DIV_LOG = $clog2(KEEP);
  localparam int HALF    = KEEP / 2;

  logic [SUM_W-1:0]  sum_q;
  logic [CODE_W-1:0] min_q, max_q;
  logic              first_q;
  logic [CODE_W-1:0] final_q;
  logic              done_q;

  logic [SUM_W-1:0]   kept;
  logic [SUM_W-1:0]   quo;
  logic [DIV_LOG-1:0] rem;
  logic [SUM_W-1:0]   rounded;

  always_comb begin
    kept    = sum_q - SUM_W'(min_q) - SUM_W'(max_q);
    quo     = kept >> DIV_LOG;
    rem     = kept[DIV_LOG-1:0];
    rounded = (rem < DIV_LOG'(HALF)) ? quo : quo + SUM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      min_q   <= '0;
      max_q   <= '0;
      first_q <= 1'b1;
      final_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_i;
      if (clr_i) begin
        sum_q   <= '0;
        first_q <= 1'b1;
      end else if (push_i) begin
        sum_q   <= sum_q + SUM_W'(val_i);
        first_q <= 1'b0;
        if (first_q || val_i < min_q) min_q <= val_i;
        if (first_q || val_i > max_q) max_q <= val_i;
      end
      if (fin_i) final_q <= rounded[CODE_W-1:0];
    end
  end

  assign final_o = final_q;
  assign done_o  = done_q;
endmodule

// File: rtl/cal_search.sv
// Bisection sequencer: trial code, conversion handshake, bound updates,
// the final +1 trial and the repeat counter.
module cal_search
  import cal_pkg::*;
#(
  parameter int SPAN   = 4096,
  parameter int REPS   = 10,
  parameter int RES_W  = 12,
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              wr_req_o,
  output logic [CODE_W-1:0] code_o,
  output logic              conv_req_o,
  output logic              push_o,
  output logic              fin_o
);
  localparam int REP_W = (REPS > 1) ? $clog2(REPS) : 1;
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(SPAN);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(SPAN / 2);

  cal_state_e        state_q;
  logic [CODE_W-1:0] hi_q, lo_q, chk_q;
  logic [REP_W-1:0]  rep_q;
  logic              zero_q, inc_pend_q, last_step_q, req_q;

  logic [CODE_W-1:0] nh, nl;
  logic [CODE_W:0]   msum;

  always_comb begin
    nh   = zero_q ? chk_q : hi_q;
    nl   = zero_q ? lo_q  : chk_q;
    msum = {1'b0, nh} + {1'b0, nl};
  end

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      hi_q        <= '0;
      lo_q        <= '0;
      chk_q       <= '0;
      rep_q       <= '0;
      zero_q      <= 1'b0;
      inc_pend_q  <= 1'b0;
      last_step_q <= 1'b0;
      req_q       <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            hi_q        <= TOP_CODE;
            lo_q        <= '0;
            chk_q       <= MID_CODE;
            rep_q       <= '0;
            inc_pend_q  <= 1'b0;
            last_step_q <= 1'b0;
            state_q     <= ST_PREP;
          end
        end
        ST_PREP:  state_q <= ST_WRITE;
        ST_WRITE: begin
          req_q   <= 1'b1;
          state_q <= ST_REQ;
        end
        ST_REQ: begin
          if (conv_done_i) begin
            zero_q  <= (conv_result_i == '0);
            req_q   <= 1'b0;
            state_q <= ST_UPDATE;
          end
        end
        ST_UPDATE: begin
          if (last_step_q) begin
            if (rep_q == REP_W'(REPS - 1)) begin
              state_q <= ST_AVG;
            end else begin
              rep_q       <= rep_q + REP_W'(1);
              hi_q        <= TOP_CODE;
              lo_q        <= '0;
              chk_q       <= MID_CODE;
              last_step_q <= 1'b0;
              state_q     <= ST_PREP;
            end
          end else if (inc_pend_q) begin
            chk_q       <= chk_q + CODE_W'(1);
            inc_pend_q  <= 1'b0;
            last_step_q <= 1'b1;
            state_q     <= ST_PREP;
          end else begin
            hi_q       <= nh;
            lo_q       <= nl;
            chk_q      <= msum[CODE_W:1];
            inc_pend_q <= ((nh - nl) == CODE_W'(1));
            state_q    <= ST_PREP;
          end
        end
        ST_AVG:  state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign wr_req_o   = (state_q == ST_PREP);
  assign code_o     = chk_q;
  assign conv_req_o = req_q;
  assign push_o     = (state_q == ST_UPDATE) && last_step_q;
  assign fin_o      = (state_q == ST_AVG);
endmodule

// File: rtl/cal_engine.sv
module cal_engine #(
  parameter int SPAN       = 4096,
  parameter int REPS       = 10,
  parameter int RES_W      = 12,
  parameter int CHAN_W     = 4,
  parameter int NUM_CONV   = 2,
  parameter int GND_CHAN_A = 15,
  parameter int GND_CHAN_B = 1,
  localparam int CODE_W    = $clog2(SPAN) + 1,
  localparam int UNIT_W    = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [UNIT_W-1:0] conv_sel_i,
  input  logic              int_gnd_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] final_code_o,
  output logic [CODE_W-1:0] trial_code_o,
  output logic              trial_we_o,
  output logic              conv_req_o,
  output logic [UNIT_W-1:0] conv_unit_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i
);
  logic              accept, wr_req, push, fin;
  logic [CODE_W-1:0] code;
  logic [UNIT_W-1:0] unit_q;
  logic [CHAN_W-1:0] chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q <= '0;
      chan_q <= '0;
    end else if (accept) begin
      unit_q <= conv_sel_i;
      if (!int_gnd_i)               chan_q <= chan_i;
      else if (conv_sel_i == '0)    chan_q <= CHAN_W'(GND_CHAN_A);
      else                          chan_q <= CHAN_W'(GND_CHAN_B);
    end
  end

  cal_search #(
    .SPAN(SPAN), .REPS(REPS), .RES_W(RES_W), .CODE_W(CODE_W)
  ) u_search (
    .clk(clk), .rst(rst), .start_i(start_i),
    .conv_done_i(conv_done_i), .conv_result_i(conv_result_i),
    .busy_o(busy_o), .accept_o(accept), .wr_req_o(wr_req),
    .code_o(code), .conv_req_o(conv_req_o), .push_o(push), .fin_o(fin)
  );

  cal_code_writer #(
    .CODE_W(CODE_W), .NUM_CONV(NUM_CONV), .UNIT_W(UNIT_W)
  ) u_writer (
    .clk(clk), .rst(rst), .wr_req_i(wr_req), .unit_i(unit_q),
    .code_i(code), .trial_code_o(trial_code_o), .trial_we_o(trial_we_o)
  );

  cal_trim_avg #(
    .CODE_W(CODE_W), .REPS(REPS)
  ) u_avg (
    .clk(clk), .rst(rst), .clr_i(accept), .push_i(push), .val_i(code),
    .fin_i(fin), .final_o(final_code_o), .done_o(done_o)
  );

  assign conv_unit_o = unit_q;
  assign conv_chan_o = chan_q;
endmodule

// File: rtl/cal_engine_chk.sv
module cal_engine_chk #(
  parameter int CODE_W = 13,
  parameter int SPAN   = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] final_code_o,
  input logic [CODE_W-1:0] trial_code_o,
  input logic              trial_we_o,
  input logic              conv_req_o,
  input logic              conv_done_i
);
  // R9
  strobe_apart_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    trial_we_o |-> !conv_req_o);
  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    trial_we_o |=> !trial_we_o);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req_o && !conv_done_i) |=> conv_req_o);
  // R9
  req_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_req_o |-> busy_o);
  // R1
  trial_range_chk: assert property (@(posedge clk) disable iff (rst)
    trial_we_o |-> (trial_code_o <= CODE_W'(SPAN)));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R11
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);
  // R11
  final_moves_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(final_code_o) |-> done_o);
  // R10
  busy_until_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind cal_engine cal_engine_chk #(.CODE_W(CODE_W), .SPAN(SPAN)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o),
  .final_code_o(final_code_o), .trial_code_o(trial_code_o),
  .trial_we_o(trial_we_o), .conv_req_o(conv_req_o), .conv_done_i(conv_done_i)
);

// File: tb/tb_cal_engine.sv
module tb_cal_engine;
  localparam int SPAN   = 4096;
  localparam int REPS   = 10;
  localparam int RES_W  = 12;
  localparam int CHAN_W = 4;
  localparam int CODE_W = 13;
  localparam int PER_SEARCH = $clog2(SPAN) + 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              start_i;
  logic              conv_sel_i;
  logic              int_gnd_i;
  logic [CHAN_W-1:0] chan_i;
  logic              busy_o, done_o, trial_we_o, conv_req_o;
  logic [CODE_W-1:0] final_code_o, trial_code_o;
  logic              conv_unit_o;
  logic [CHAN_W-1:0] conv_chan_o;
  logic              conv_done_i;
  logic [RES_W-1:0]  conv_result_i;

  always #5 clk = ~clk;

  cal_engine dut (
    .clk(clk), .rst(rst), .start_i(start_i), .conv_sel_i(conv_sel_i),
    .int_gnd_i(int_gnd_i), .chan_i(chan_i), .busy_o(busy_o), .done_o(done_o),
    .final_code_o(final_code_o), .trial_code_o(trial_code_o),
    .trial_we_o(trial_we_o), .conv_req_o(conv_req_o),
    .conv_unit_o(conv_unit_o), .conv_chan_o(conv_chan_o),
    .conv_done_i(conv_done_i), .conv_result_i(conv_result_i)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int exp_wr_q[$];
  int exp_fin_q[$];
  int offs[REPS];
  int reg_code[2] = '{0, 0};
  int last_b[2]   = '{8191, 8191};
  int conv_cnt    = 0;
  int done_cnt    = 0;
  int exp_unit    = 0;
  int exp_chan    = 0;
  bit first_wr_chk = 0;
  bit req_prev = 0, done_prev = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected write: filtered by the bench's own per-converter record (R8)
  task automatic bwrite(input int unit, input int code);
    if (code != last_b[unit]) begin
      exp_wr_q.push_back(code);
      last_b[unit] = code;
    end
  endtask

  task automatic predict(input int unit);
    int res[REPS];
    int hi, lo, c, sum, mn, mx, kept;
    bit z;
    for (int r = 0; r < REPS; r++) begin
      hi = SPAN; lo = 0; c = (hi + lo) / 2;
      bwrite(unit, c); z = (c >= offs[r]);
      while (hi - lo > 1) begin
        if (z) hi = c; else lo = c;
        c = (hi + lo) / 2;
        bwrite(unit, c); z = (c >= offs[r]);
        if (hi - lo == 1) begin
          c = c + 1;
          bwrite(unit, c); z = (c >= offs[r]);
        end
      end
      res[r] = c;
    end
    sum = 0; mn = res[0]; mx = res[0];
    for (int r = 0; r < REPS; r++) begin
      sum += res[r];
      if (res[r] < mn) mn = res[r];
      if (res[r] > mx) mx = res[r];
    end
    kept = sum - mn - mx;
    exp_fin_q.push_back(((kept % 8) < 4) ? kept / 8 : kept / 8 + 1);
  endtask

  task automatic run_cal(input int unit, input bit gnd, input int ch, input bit intrude);
    int target;
    int fin_exp;
    exp_unit = unit;
    exp_chan = gnd ? ((unit == 0) ? 15 : 1) : ch;
    conv_cnt = 0;
    predict(unit);
    fin_exp = exp_fin_q[exp_fin_q.size() - 1];
    target = done_cnt + 1;
    @(posedge clk); #1;
    start_i = 1'b1; conv_sel_i = unit[0]; int_gnd_i = gnd; chan_i = CHAN_W'(ch);
    @(posedge clk); #1;
    start_i = 1'b0;
    if (intrude) begin
      repeat (60) @(posedge clk);
      #1;
      // R10: a second start in the middle of a run must change nothing
      start_i = 1'b1; conv_sel_i = ~unit[0]; int_gnd_i = ~gnd; chan_i = 4'd3;
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    while (done_cnt < target) @(posedge clk);
    @(negedge clk);
    check(busy_o == 1'b0, "R11 busy after done", busy_o, 0);
    check(conv_cnt == REPS * PER_SEARCH, "R4 R3 conversion count", conv_cnt, REPS * PER_SEARCH);
    repeat (20) @(negedge clk);
    check(int'(final_code_o) == fin_exp, "R11 final code held", final_code_o, fin_exp);
    check(busy_o == 1'b0 && conv_cnt == REPS * PER_SEARCH, "R10 no restart from ignored start",
          conv_cnt, REPS * PER_SEARCH);
  endtask

  // converter model: zero result once the stored trim code reaches the offset
  initial begin
    int idx, lat, rp, off;
    conv_done_i = 1'b0;
    conv_result_i = '0;
    forever begin
      @(posedge clk); #1;
      if (!rst && conv_req_o && !conv_done_i) begin
        idx = conv_cnt;
        lat = idx % 3;
        rp  = idx / PER_SEARCH;
        if (rp > REPS - 1) rp = REPS - 1;
        off = offs[rp];
        repeat (lat) begin @(posedge clk); #1; end
        conv_result_i = (reg_code[conv_unit_o] < off) ? RES_W'(1 + idx % 7) : '0;
        conv_done_i = 1'b1;
        conv_cnt++;
        @(posedge clk); #1;
        conv_done_i = 1'b0;
      end
    end
  end

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (trial_we_o) begin
        reg_code[conv_unit_o] = int'(trial_code_o);
        if (exp_wr_q.size() == 0) begin
          check(0, "R8 unexpected write strobe", trial_code_o, -1);
        end else begin
          int e;
          e = exp_wr_q.pop_front();
          if (first_wr_chk) begin
            check(trial_code_o == 13'd2048, "R1 first trial code", trial_code_o, 2048);
            first_wr_chk = 0;
          end
          check(int'(trial_code_o) == e, "R2 R8 trial code sequence", trial_code_o, e);
        end
        check(int'(conv_unit_o) == exp_unit, "R7 write unit", conv_unit_o, exp_unit);
      end
      if (conv_req_o && !req_prev) begin
        check(int'(conv_unit_o) == exp_unit, "R7 request unit", conv_unit_o, exp_unit);
        check(int'(conv_chan_o) == exp_chan, "R7 request channel", conv_chan_o, exp_chan);
      end
      if (done_o) begin
        check(!done_prev, "R11 done width", 2, 1);
        check(busy_o, "R11 busy during done", busy_o, 1);
        if (exp_fin_q.size() == 0) begin
          check(0, "R11 unexpected done", final_code_o, -1);
        end else begin
          int f;
          f = exp_fin_q.pop_front();
          check(int'(final_code_o) == f, "R5 R6 final code", final_code_o, f);
        end
        done_cnt++;
      end
      req_prev  = conv_req_o;
      done_prev = done_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 7);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; conv_sel_i = 1'b0; int_gnd_i = 1'b0; chan_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(busy_o == 0, "R12 busy at reset", busy_o, 0);
    check(done_o == 0, "R12 done at reset", done_o, 0);
    check(conv_req_o == 0, "R12 request at reset", conv_req_o, 0);
    check(trial_we_o == 0, "R12 strobe at reset", trial_we_o, 0);
    check(final_code_o == 0, "R12 final at reset", final_code_o, 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R1 R2 R3 R4: steady offset
    for (int i = 0; i < REPS; i++) offs[i] = 1000;
    first_wr_chk = 1;
    run_cal(0, 0, 5, 0);

    // R5: outliers at both ends
    offs = '{100, 4000, 1200, 1201, 1203, 1199, 1202, 1200, 1198, 1205};
    run_cal(1, 1, 0, 0);

    // R6: remainder 4 rounds up (kept sum 4004 -> 501)
    offs = '{500, 500, 10, 500, 500, 504, 500, 3000, 500, 500};
    run_cal(0, 1, 0, 0);

    // R6 R10: remainder 3 rounds down (kept sum 4003 -> 500), start mid-run
    offs = '{500, 500, 10, 500, 500, 503, 500, 3000, 500, 500};
    run_cal(1, 0, 9, 1);

    // R8: every search ends on 2048, so the next opening write is skipped
    for (int i = 0; i < REPS; i++) offs[i] = 2048;
    run_cal(1, 0, 12, 0);

    // R3: top of range
    for (int i = 0; i < REPS; i++) offs[i] = 4096;
    run_cal(0, 0, 7, 0);

    // R3: bottom of range
    for (int i = 0; i < REPS; i++) offs[i] = 1;
    run_cal(1, 1, 0, 0);

    check(exp_wr_q.size() == 0, "R8 writes left over", exp_wr_q.size(), 0);
    check(exp_fin_q.size() == 0, "R11 results left over", exp_fin_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule